// File: doc/BRIEF.md
# Physical Page List Segment Walker

The walker turns one host transfer descriptor into the sequence of contiguous memory segments that the transfer occupies. A descriptor carries a byte count and two 64-bit physical pointers. The first pointer may sit anywhere inside a page. The second pointer can take one of three roles, depending on how many bytes are left after the first page:
- unused, when nothing is left;
- the final data page itself, when at most one page is left;
- the address of a list of 8-byte little-endian page pointers, when more remains.

A list that runs out of slots spends its last slot on a pointer to the next list.

A host side or DMA engine pulses `start` with the descriptor and then consumes one (address, length) segment per `seg_valid` cycle. List entries are read through a single-outstanding request/response memory port, one entry at a time and only as far as the transfer needs. The walk ends with a one-cycle `done` pulse that carries the status. An error status means that all segments already delivered for this descriptor must be discarded. The walker does not move data.

Top module: `prp_walker`

## Requirements
- R1: The page size is 2^(12 + `page_sel`) bytes, with `page_sel` sampled at `start`. A list holds page/8 entries, so its last slot is index page/8 − 1.
- R2: A zero `data_ptr0` ends the walk with `status_err` = 1 and no segment emitted.
- R3: The first segment is at `data_ptr0`. Its length is the smaller of `xfer_len` and page − (`data_ptr0` mod page).
- R4: When bytes remain after the first segment and `data_ptr1` is zero, the walk ends with an error after that first segment.
- R5: When 1..page bytes remain, the second and last segment is (`data_ptr1`, remaining). An unaligned `data_ptr1` in this case is an error.
- R6: When more than a page remains, entry i of the current list is read at list_base + 8·i, with `data_ptr1` as the first list base. Each data entry yields a segment (entry, min(remaining, page)), and no entry past the one that completes the transfer is read.
- R7: At the last slot of a list, if more than one page still remains, the entry is the base of the next list and reading restarts at its index 0. That entry must be nonzero and page-aligned, otherwise the walk ends with an error. With exactly one page or less remaining, the last slot is an ordinary data entry.
- R8: A data entry that is zero or not page-aligned ends the walk with an error, and no segment is emitted for it.
- R9: `done` is a one-cycle pulse with `status_err` valid in the same cycle. On success the final segment appears in the `done` cycle and the segment lengths sum to `xfer_len`.
- R10: `busy` is high from the cycle after an accepted `start` until `done`. A `start` while busy is ignored.
- R11: A read request holds its address until `rd_req_ready` accepts it. There is never more than one read outstanding.
- R12: A synchronous active-low reset returns the walker to idle with no request, segment or `done` pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Accept a descriptor when idle |
| page_sel | input | 3 | Page size selector, page = 2^(12+page_sel) |
| xfer_len | input | 32 | Transfer length in bytes |
| data_ptr0 | input | 64 | First page pointer, any offset |
| data_ptr1 | input | 64 | Second page pointer or list base |
| busy | output | 1 | Walk in progress |
| rd_req_valid | output | 1 | Entry read request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 64 | Byte address of the 8-byte entry |
| rd_rsp_valid | input | 1 | Entry data returned |
| rd_rsp_data | input | 64 | Entry value |
| seg_valid | output | 1 | Segment strobe |
| seg_addr | output | 64 | Segment start address |
| seg_len | output | 32 | Segment length in bytes |
| done | output | 1 | Walk finished, one-cycle pulse |
| status_err | output | 1 | Invalid-field status, valid with done |

## Verification
The final segment strobe and the completion pulse share one cycle on every successful walk. The bench therefore records, at the moment `done` is seen, whether `seg_valid` was also high, and expects it on each passing descriptor: single page, two direct pages, short list, list with a wider page, and a chained list of 600 pages. Error walks are judged the other way round: the number of segments counted before the error pulse must match the point of failure, and no segment may share the error cycle.

// File: rtl/prp_pkg.sv
// Shared types for the page list walker.
// Assumes: nothing beyond IEEE 1800-2017.
package prp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_DIRECT,
        ST_FETCH,
        ST_WAIT,
        ST_FAIL
    } walk_st_t;

endpackage

// File: rtl/prp_page_geom.sv
// Page geometry: derives page size, offset mask, last list slot and the room
// left in the first page from the size selector and the first pointer.
// Assumes: LEN_W is wider than the largest page shift; purely combinational.
module prp_page_geom #(
    parameter int MPS_W  = 3,
    parameter int LEN_W  = 32,
    parameter int ADDR_W = 64
) (
    input  logic [MPS_W-1:0]  mps,
    input  logic [ADDR_W-1:0] first_ptr,
    output logic [LEN_W-1:0]  page_bytes,
    output logic [ADDR_W-1:0] off_mask,
    output logic [LEN_W-1:0]  last_slot,
    output logic [LEN_W-1:0]  first_room
);
    localparam int SHIFT_MAX = 12 + (1 << MPS_W) - 1;
    localparam int SH_W      = $clog2(SHIFT_MAX + 1);

    logic [SH_W-1:0] shift;

    // Page size, mask and slot count from the selector
    always_comb begin
        shift      = SH_W'(12) + SH_W'(mps);
        page_bytes = LEN_W'(1) << shift;
        off_mask   = {{(ADDR_W-LEN_W){1'b0}}, page_bytes} - ADDR_W'(1);
        last_slot  = (page_bytes >> 3) - LEN_W'(1);
        first_room = page_bytes - LEN_W'(first_ptr & off_mask);
    end

endmodule

// File: rtl/prp_entry_fetch.sv
// Entry fetcher: turns a one-cycle go with an address into a single
// request/response transaction and returns the entry for one cycle.
// Assumes: go only arrives when no transaction is open.
module prp_entry_fetch #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] go_addr,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [63:0]       rd_rsp_data,
    output logic              ent_valid,
    output logic [63:0]       ent_data
);
    logic req_q;
    logic wait_q;
    logic [ADDR_W-1:0] addr_q;

    // Request and response tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            wait_q <= 1'b0;
            addr_q <= '0;
        end else if (go) begin
            req_q  <= 1'b1;
            addr_q <= go_addr;
        end else if (req_q && rd_req_ready) begin
            req_q  <= 1'b0;
            wait_q <= 1'b1;
        end else if (wait_q && rd_rsp_valid) begin
            wait_q <= 1'b0;
        end
    end

    // Drive the port and hand the entry back
    always_comb begin
        rd_req_valid = req_q;
        rd_req_addr  = addr_q;
        ent_valid    = wait_q && rd_rsp_valid;
        ent_data     = rd_rsp_data;
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

    // R11
    one_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !req_q && !wait_q);

endmodule

// File: rtl/prp_walker.sv
// Segment walker: splits a transfer into page segments from two pointers,
// fetching and chaining pointer lists when the transfer spans many pages.
// Assumes: one descriptor at a time; segment consumer always accepts.
module prp_walker #(
    parameter int MPS_W  = 3,
    parameter int LEN_W  = 32,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MPS_W-1:0]  page_sel,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic [ADDR_W-1:0] data_ptr0,
    input  logic [ADDR_W-1:0] data_ptr1,
    output logic              busy,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [63:0]       rd_rsp_data,
    output logic              seg_valid,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [LEN_W-1:0]  seg_len,
    output logic              done,
    output logic              status_err
);
    import prp_pkg::*;

    walk_st_t          st_q;
    logic [MPS_W-1:0]  mps_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  rem_q;
    logic [ADDR_W-1:0] ptr0_q;
    logic [ADDR_W-1:0] ptr1_q;
    logic [ADDR_W-1:0] list_q;
    logic [LEN_W-1:0]  idx_q;

    logic              seg_v_q;
    logic [ADDR_W-1:0] seg_a_q;
    logic [LEN_W-1:0]  seg_l_q;
    logic              done_q;
    logic              err_q;

    logic [LEN_W-1:0]  page_bytes;
    logic [ADDR_W-1:0] off_mask;
    logic [LEN_W-1:0]  last_slot;
    logic [LEN_W-1:0]  first_room;

    logic              go;
    logic [ADDR_W-1:0] entry_addr;
    logic              ent_valid;
    logic [63:0]       ent_data;

    logic [LEN_W-1:0]  first_take;
    logic [LEN_W-1:0]  after_first;
    logic [LEN_W-1:0]  list_take;
    logic              ent_bad;
    logic              ptr1_unaligned;
    logic              chain_slot;

    prp_page_geom #(.MPS_W(MPS_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_geom (
        .mps        (mps_q),
        .first_ptr  (ptr0_q),
        .page_bytes (page_bytes),
        .off_mask   (off_mask),
        .last_slot  (last_slot),
        .first_room (first_room)
    );

    prp_entry_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (go),
        .go_addr      (entry_addr),
        .rd_req_valid (rd_req_valid),
        .rd_req_ready (rd_req_ready),
        .rd_req_addr  (rd_req_addr),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_data  (rd_rsp_data),
        .ent_valid    (ent_valid),
        .ent_data     (ent_data)
    );

    // Segment sizing and pointer validity for the current step
    always_comb begin
        first_take     = (len_q < first_room) ? len_q : first_room;
        after_first    = len_q - first_take;
        list_take      = (rem_q > page_bytes) ? page_bytes : rem_q;
        ent_bad        = (ent_data == 64'd0) || ((ent_data & off_mask) != '0);
        ptr1_unaligned = (ptr1_q & off_mask) != '0;
        chain_slot     = (idx_q == last_slot) && (rem_q > page_bytes);
        entry_addr     = list_q + ADDR_W'({idx_q, 3'b000});
        go             = (st_q == ST_FETCH);
    end

    // Walk sequencing, segment emission and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            mps_q   <= '0;
            len_q   <= '0;
            rem_q   <= '0;
            ptr0_q  <= '0;
            ptr1_q  <= '0;
            list_q  <= '0;
            idx_q   <= '0;
            seg_v_q <= 1'b0;
            seg_a_q <= '0;
            seg_l_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            seg_v_q <= 1'b0;
            done_q  <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        mps_q  <= page_sel;
                        len_q  <= xfer_len;
                        ptr0_q <= data_ptr0;
                        ptr1_q <= data_ptr1;
                        st_q   <= ST_FIRST;
                    end
                end
                ST_FIRST: begin
                    if (ptr0_q == '0) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                        st_q   <= ST_IDLE;
                    end else begin
                        seg_v_q <= 1'b1;
                        seg_a_q <= ptr0_q;
                        seg_l_q <= first_take;
                        rem_q   <= after_first;
                        if (after_first == '0) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b0;
                            st_q   <= ST_IDLE;
                        end else if (ptr1_q == '0) begin
                            st_q <= ST_FAIL;
                        end else if (after_first <= page_bytes) begin
                            st_q <= ptr1_unaligned ? ST_FAIL : ST_DIRECT;
                        end else begin
                            list_q <= ptr1_q;
                            idx_q  <= '0;
                            st_q   <= ST_FETCH;
                        end
                    end
                end
                ST_DIRECT: begin
                    seg_v_q <= 1'b1;
                    seg_a_q <= ptr1_q;
                    seg_l_q <= rem_q;
                    done_q  <= 1'b1;
                    err_q   <= 1'b0;
                    st_q    <= ST_IDLE;
                end
                ST_FETCH: begin
                    st_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (ent_valid) begin
                        if (ent_bad) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else if (chain_slot) begin
                            list_q <= ent_data;
                            idx_q  <= '0;
                            st_q   <= ST_FETCH;
                        end else begin
                            seg_v_q <= 1'b1;
                            seg_a_q <= ent_data;
                            seg_l_q <= list_take;
                            rem_q   <= rem_q - list_take;
                            idx_q   <= idx_q + LEN_W'(1);
                            if (rem_q == list_take) begin
                                done_q <= 1'b1;
                                err_q  <= 1'b0;
                                st_q   <= ST_IDLE;
                            end else begin
                                st_q <= ST_FETCH;
                            end
                        end
                    end
                end
                ST_FAIL: begin
                    done_q <= 1'b1;
                    err_q  <= 1'b1;
                    st_q   <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Output wiring
    always_comb begin
        busy       = (st_q != ST_IDLE);
        seg_valid  = seg_v_q;
        seg_addr   = seg_a_q;
        seg_len    = seg_l_q;
        done       = done_q;
        status_err = err_q;
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    seg_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> seg_addr != '0);

    // R6
    seg_fits_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> seg_len <= page_bytes);

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(len_q) && $stable(ptr0_q));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req_valid);

endmodule

// File: tb/prp_walker_tb.sv
module prp_walker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  page_sel = '0;
    logic [31:0] xfer_len = '0;
    logic [63:0] data_ptr0 = '0;
    logic [63:0] data_ptr1 = '0;
    logic        busy;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b1;
    logic [63:0] rd_req_addr;
    logic        rd_rsp_valid = 1'b0;
    logic [63:0] rd_rsp_data = '0;
    logic        seg_valid;
    logic [63:0] seg_addr;
    logic [31:0] seg_len;
    logic        done;
    logic        status_err;

    int n_chk = 0;
    int n_fail = 0;

    logic        stall = 1'b0;
    logic        poison_en = 1'b0;
    logic [63:0] poison_addr = '0;
    logic [63:0] poison_val = '0;
    logic [63:0] watch_addr = '1;
    logic        watch_hit = 1'b0;

    int          m_cnt;
    logic [63:0] m_sum;
    logic [31:0] m_len1;
    logic [31:0] m_last;
    logic [63:0] m_a2;
    logic        m_done;
    logic        m_err;
    logic        m_seg_at_done;

    typedef struct packed {
        logic [2:0]  mps;
        logic [31:0] len;
        logic [63:0] p0;
        logic [63:0] p1;
        logic        ok;
        logic [15:0] cnt;
        logic [31:0] flen;
        logic [31:0] llen;
        logic [63:0] a2;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        // R3: single partial page
        '{3'd0, 32'd100, 64'h1000_0010, 64'h0, 1'b1, 16'd1, 32'd100, 32'd100, 64'h0},
        // R5: offset first page, direct second
        '{3'd0, 32'd4096, 64'h2000_0800, 64'h3000_0000, 1'b1, 16'd2, 32'd2048, 32'd2048, 64'h3000_0000},
        // R5: two whole pages
        '{3'd0, 32'd8192, 64'h4000_0000, 64'h3100_0000, 1'b1, 16'd2, 32'd4096, 32'd4096, 64'h3100_0000},
        // R6: short list, entries are address<<12
        '{3'd0, 32'd12388, 64'h5000_0F00, 64'h0900_0000, 1'b1, 16'd4, 32'd256, 32'd3940, 64'h90_0000_0000},
        // R2: zero first pointer
        '{3'd0, 32'd100, 64'h0, 64'h0, 1'b0, 16'd0, 32'd0, 32'd0, 64'h0},
        // R4: zero second pointer with bytes left
        '{3'd0, 32'd5000, 64'h1000, 64'h0, 1'b0, 16'd1, 32'd4096, 32'd4096, 64'h0},
        // R5: unaligned direct second pointer
        '{3'd0, 32'd5000, 64'h1000, 64'h3000_0010, 1'b0, 16'd1, 32'd4096, 32'd4096, 64'h0},
        // R1: 8 KiB pages through a list
        '{3'd1, 32'd20000, 64'h6000_0000, 64'h7000_0000, 1'b1, 16'd3, 32'd8192, 32'd3616, 64'h700_0000_0000}
    };

    prp_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .page_sel(page_sel),
        .xfer_len(xfer_len), .data_ptr0(data_ptr0), .data_ptr1(data_ptr1),
        .busy(busy), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_data(rd_rsp_data), .seg_valid(seg_valid), .seg_addr(seg_addr),
        .seg_len(seg_len), .done(done), .status_err(status_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: one-cycle response, entry value = address shifted by 12
    always @(posedge clk) begin
        rd_rsp_valid <= rd_req_valid && rd_req_ready;
        rd_rsp_data  <= (poison_en && rd_req_addr == poison_addr) ? poison_val
                                                                  : {rd_req_addr[51:0], 12'h000};
        if (rd_req_valid && rd_req_ready && rd_req_addr == watch_addr) watch_hit <= 1'b1;
        rd_req_ready <= stall ? ~rd_req_ready : 1'b1;
    end

    // Segment and completion monitor
    always @(negedge clk) begin
        if (seg_valid) begin
            m_cnt  = m_cnt + 1;
            m_sum  = m_sum + 64'(seg_len);
            if (m_cnt == 1) m_len1 = seg_len;
            if (m_cnt == 2) m_a2 = seg_addr;
            m_last = seg_len;
        end
        if (done) begin
            m_done        = 1'b1;
            m_err         = status_err;
            m_seg_at_done = seg_valid;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic begin_run(input logic [2:0] m, input logic [31:0] l,
                             input logic [63:0] a, input logic [63:0] b);
        @(posedge clk); #1;
        m_cnt = 0; m_sum = '0; m_len1 = '0; m_last = '0; m_a2 = '0;
        m_done = 1'b0; m_err = 1'b0; m_seg_at_done = 1'b0;
        watch_hit = 1'b0;
        page_sel = m; xfer_len = l; data_ptr0 = a; data_ptr1 = b;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_run();
        int n = 0;
        while (!m_done && n < 20000) begin
            @(posedge clk);
            n++;
        end
        #1;
        if (!m_done) chk("R9 watchdog expired", 64'd0, 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R12: reset state
        chk("R12 busy after reset", 64'(busy), 64'd0);
        chk("R12 no request after reset", 64'(rd_req_valid), 64'd0);
        chk("R12 no segment/done after reset", 64'({seg_valid, done}), 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            begin_run(VECS[i].mps, VECS[i].len, VECS[i].p0, VECS[i].p1);
            wait_run();
            chk("R9 status", 64'(m_err), 64'(!VECS[i].ok));
            chk("R3 segment count", 64'(m_cnt), 64'(VECS[i].cnt));
            if (VECS[i].cnt > 0) begin
                chk("R3 first length", 64'(m_len1), 64'(VECS[i].flen));
                chk("R6 last length", 64'(m_last), 64'(VECS[i].llen));
            end
            if (VECS[i].cnt > 1) chk("R6 second address", m_a2, VECS[i].a2);
            if (VECS[i].ok) begin
                chk("R9 length sum", m_sum, 64'(VECS[i].len));
                chk("R9 final segment with done", 64'(m_seg_at_done), 64'd1);
            end
        end

        // R8: unaligned data entry at list index 1
        poison_en = 1'b1; poison_addr = 64'h8000_0008; poison_val = 64'h1234;
        begin_run(3'd0, 32'd16384, 64'h1000, 64'h8000_0000);
        wait_run();
        chk("R8 unaligned entry status", 64'(m_err), 64'd1);
        chk("R8 segments before error", 64'(m_cnt), 64'd2);
        chk("R8 no segment in error cycle", 64'(m_seg_at_done), 64'd0);

        // R8: zero data entry at index 0
        poison_addr = 64'h8000_0000; poison_val = 64'h0;
        begin_run(3'd0, 32'd16384, 64'h1000, 64'h8000_0000);
        wait_run();
        chk("R8 zero entry status", 64'(m_err), 64'd1);
        chk("R8 zero entry count", 64'(m_cnt), 64'd1);
        poison_en = 1'b0;

        // R7 and R10: chained list over 600 pages, stray start mid-walk
        watch_addr = {(64'h8000_0000 + 64'd4088), 12'h000} ;
        watch_addr = {watch_addr[63:12], 12'h000};
        watch_addr = (64'h8000_0000 + 64'd4088) << 12;
        begin_run(3'd0, 32'd2457600, 64'h10000, 64'h8000_0000);
        repeat (40) @(posedge clk);
        #1;
        chk("R10 busy during walk", 64'(busy), 64'd1);
        page_sel = 3'd0; xfer_len = 32'd1; data_ptr0 = 64'h0; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        wait_run();
        chk("R10 stray start ignored status", 64'(m_err), 64'd0);
        chk("R7 chained segment count", 64'(m_cnt), 64'd600);
        chk("R7 chained length sum", m_sum, 64'd2457600);
        chk("R7 next list read", 64'(watch_hit), 64'd1);
        chk("R9 chained final with done", 64'(m_seg_at_done), 64'd1);

        // R7: bad chain pointer
        poison_en = 1'b1; poison_addr = 64'h8000_0000 + 64'd4088; poison_val = 64'h5;
        begin_run(3'd0, 32'd2457600, 64'h10000, 64'h8000_0000);
        wait_run();
        chk("R7 bad chain status", 64'(m_err), 64'd1);
        chk("R7 bad chain count", 64'(m_cnt), 64'd512);
        poison_en = 1'b0;

        // R7: exactly one page left at last slot is data
        begin_run(3'd0, 32'd2101248, 64'h10000, 64'h8000_0000);
        wait_run();
        chk("R7 last slot as data status", 64'(m_err), 64'd0);
        chk("R7 last slot as data count", 64'(m_cnt), 64'd513);

        // R11: stalled request port gives the same walk
        stall = 1'b1;
        begin_run(3'd0, 32'd12388, 64'h5000_0F00, 64'h0900_0000);
        wait_run();
        chk("R11 stalled status", 64'(m_err), 64'd0);
        chk("R11 stalled count", 64'(m_cnt), 64'd4);
        chk("R11 stalled last length", 64'(m_last), 64'd3940);
        stall = 1'b0;

        // R12: reset in the middle of a walk
        begin_run(3'd0, 32'd2457600, 64'h10000, 64'h8000_0000);
        repeat (30) @(posedge clk);
        #1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R12 mid-walk reset busy", 64'(busy), 64'd0);
        chk("R12 mid-walk reset request", 64'(rd_req_valid), 64'd0);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Global watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 global watchdog actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule